// File: doc/BRIEF.md
# Boot strap capture and downstream port-power gating

This block sits beside the chip's external active-low reset pin. While that pin holds the chip in a qualified reset, the block samples a set of configuration straps every cycle. The straps are a port-power polarity, a clock-source mode, a two-bit clock-frequency select and a program-memory select. The block freezes these values when reset is released. It also drives the weak pull-down enable for the clock straps and the weak pull-up enable for the program-memory strap. After release those pins become ordinary functional I/O, so the pulls must be switched off.

The block also drives the downstream port-power enables. Their active level follows the polarity strap. Whenever the reset pin is low, the outputs are forced to the inactive level by combinational logic from the live polarity pin, so no port is powered even before the clock has sampled anything. After release, each output follows the hub's power request, corrected by the latched polarity.

The reset pin first passes through a two-flop synchroniser and then a low-time qualifier. A low pulse shorter than `MIN_LOW` clock cycles is treated as a glitch and does not restart strap capture. A separate synchronous active-high `rst` initialises the block's own flops.

Top module: `boot_strap_ctl`

## Requirements
- R1: After release, with a latched polarity of 1, `port_pwr[i]` equals `port_req[i]` (active high). With a latched polarity of 0, `port_pwr[i]` equals the inverse of `port_req[i]` (active low).
- R2: While `rst_pin_n` is low or `rst` is high, every `port_pwr` bit equals the inverse of the live `pol_pin`, whatever `port_req` is, with no clock edge needed.
- R3: After release, changes on `pol_pin` have no effect on `port_pwr`; the latched polarity is used.
- R4: While the qualified reset is active, the straps are sampled on every clock edge, and the value seen on the releasing edge is kept. The `strap_status` layout is: bit 0 polarity, bit 1 clock mode, bits 3:2 clock select, bit 4 program-memory select.
- R5: `strap_status[4]` holds the latched level of `prog_mem_pin`; 1 (high or pulled up) means internal program memory.
- R6: `clk_strap_pd_en` is 1 while the qualified reset is active. It returns to 0 on the third rising clock edge after `rst_pin_n` rises, so it stays high for two sampled cycles after the rise.
- R7: `prog_strap_pu_en` is 1 whenever `clk_strap_pd_en` is 1. It stays 1 for exactly `REL_DLY` (default 8) cycles after `clk_strap_pd_en` falls, so it stays high for `REL_DLY`+2 cycles after the pin rises.
- R8: A low pulse on `rst_pin_n` lasting fewer than `MIN_LOW` (default 24) clock edges is ignored: the pull enables stay 0 and `strap_status` does not change.
- R9: A low pulse lasting `MIN_LOW` clock edges or more is a valid reset: the pull enables assert and the straps are captured again.
- R10: After release, `strap_status` keeps its value while the strap pins change, until the next valid reset.
- R11: While `rst` is high, both pull enables are 1 and, after the first edge, `strap_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high initialisation of the block's flops |
| rst_pin_n | input | 1 | Raw external active-low reset pin |
| pol_pin | input | 1 | Live port-power polarity strap |
| clk_mode_pin | input | 1 | Clock-source mode strap |
| clk_sel_pin | input | 2 | Clock-frequency select strap |
| prog_mem_pin | input | 1 | Program-memory select strap |
| port_req | input | NPORT | Per-port power requests from the hub logic |
| clk_strap_pd_en | output | 1 | Weak pull-down enable on the clock strap pins |
| prog_strap_pu_en | output | 1 | Weak pull-up enable on the program-memory strap pin |
| strap_status | output | 5 | Read-only latched strap word |
| port_pwr | output | NPORT | Polarity-corrected port-power enables |

## Verification
Faults show up at three places:
- A qualifier that counts wrongly shows as a pull-down that does or does not rise after a 23-edge or 24-edge pulse, visible within about 26 cycles of the pulse start.
- A capture register that keeps sampling after release shows at once as a status word that follows the pins.
- A wrong release-delay count shows as a pull-up window one or more cycles off from 10.

Polarity errors appear on `port_pwr` in the same cycle the request or pin changes, so every polarity and request combination is compared both inside and outside reset.

// File: rtl/bstrap_pkg.sv
package bstrap_pkg;

    // Latched strap word; bit positions are part of the status layout.
    typedef struct packed {
        logic       rom_int;   // bit 4: 1 selects internal program memory
        logic [1:0] clk_sel;   // bits 3:2
        logic       clk_mode;  // bit 1
        logic       pwr_pol;   // bit 0: 1 = active-high port power
    } strap_t;

    localparam int STRAP_W = $bits(strap_t);

    // Counter width that can hold values 0..n-1 (at least one bit).
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Level that leaves a port unpowered for a given polarity.
    function automatic logic idle_level(input logic pol);
        return ~pol;
    endfunction

    // Request mapped onto the pin level for a given polarity.
    function automatic logic drive_level(input logic req, input logic pol);
        return req ^ ~pol;
    endfunction

endpackage

// File: rtl/bstrap_rst_qual.sv
module bstrap_rst_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic held
);
    localparam int CW = bstrap_pkg::cnt_width(MIN_LOW);
    localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          low_cnt;
    logic                   pin_s;

    assign pin_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
        end
    end

    // Count consecutive low samples; saturate at the qualifying count.
    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            held    <= 1'b1;
        end else if (pin_s) begin
            low_cnt <= '0;
            held    <= 1'b0;
        end else begin
            if (low_cnt != LAST) begin
                low_cnt <= low_cnt + 1'b1;
            end
            if (low_cnt == LAST) begin
                held <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/bstrap_capture.sv
module bstrap_capture #(
    parameter int REL_DLY = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                held,
    input  bstrap_pkg::strap_t  live,
    output bstrap_pkg::strap_t  latched,
    output logic                pd_en,
    output logic                pu_en
);
    localparam int RW = bstrap_pkg::cnt_width(REL_DLY + 1);
    localparam logic [RW-1:0] DLY = RW'(REL_DLY);

    logic [RW-1:0] rel_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            latched <= '0;
            rel_cnt <= DLY;
        end else begin
            if (held) begin
                latched <= live;
                rel_cnt <= DLY;
            end else if (rel_cnt != '0) begin
                rel_cnt <= rel_cnt - 1'b1;
            end
        end
    end

    assign pd_en = held;
    assign pu_en = held | (rel_cnt != '0);

endmodule

// File: rtl/bstrap_port_gate.sv
module bstrap_port_gate #(
    parameter int NPORT = 3
) (
    input  logic             rst,
    input  logic             pin_n,
    input  logic             held,
    input  logic             live_pol,
    input  logic             latched_pol,
    input  logic [NPORT-1:0] req,
    output logic [NPORT-1:0] port_pwr
);
    logic force_idle;

    // Raw pin participates directly so gating needs no clock edge.
    assign force_idle = rst | ~pin_n | held;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        assign port_pwr[g] = force_idle
                           ? bstrap_pkg::idle_level(live_pol)
                           : bstrap_pkg::drive_level(req[g], latched_pol);
    end

endmodule

// File: rtl/boot_strap_ctl.sv
module boot_strap_ctl #(
    parameter int NPORT       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 24,
    parameter int REL_DLY     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_pin_n,
    input  logic             pol_pin,
    input  logic             clk_mode_pin,
    input  logic [1:0]       clk_sel_pin,
    input  logic             prog_mem_pin,
    input  logic [NPORT-1:0] port_req,
    output logic             clk_strap_pd_en,
    output logic             prog_strap_pu_en,
    output logic [4:0]       strap_status,
    output logic [NPORT-1:0] port_pwr
);
    bstrap_pkg::strap_t live_s;
    bstrap_pkg::strap_t latched_s;
    logic               held;

    assign live_s.rom_int  = prog_mem_pin;
    assign live_s.clk_sel  = clk_sel_pin;
    assign live_s.clk_mode = clk_mode_pin;
    assign live_s.pwr_pol  = pol_pin;

    bstrap_rst_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .MIN_LOW     (MIN_LOW)
    ) u_qual (
        .clk   (clk),
        .rst   (rst),
        .pin_n (rst_pin_n),
        .held  (held)
    );

    bstrap_capture #(
        .REL_DLY (REL_DLY)
    ) u_cap (
        .clk     (clk),
        .rst     (rst),
        .held    (held),
        .live    (live_s),
        .latched (latched_s),
        .pd_en   (clk_strap_pd_en),
        .pu_en   (prog_strap_pu_en)
    );

    bstrap_port_gate #(
        .NPORT (NPORT)
    ) u_gate (
        .rst         (rst),
        .pin_n       (rst_pin_n),
        .held        (held),
        .live_pol    (pol_pin),
        .latched_pol (latched_s.pwr_pol),
        .req         (port_req),
        .port_pwr    (port_pwr)
    );

    assign strap_status = latched_s;

endmodule

// File: rtl/bstrap_checker.sv
module bstrap_checker #(
    parameter int NPORT = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             rst_pin_n,
    input logic             pol_pin,
    input logic [NPORT-1:0] port_req,
    input logic             clk_strap_pd_en,
    input logic             prog_strap_pu_en,
    input logic [4:0]       strap_status,
    input logic [NPORT-1:0] port_pwr
);
    // R2: pin low keeps every port at the live inactive level
    p_idle_in_reset_r2: assert property (@(posedge clk) disable iff (rst)
        !rst_pin_n |-> (port_pwr == {NPORT{~pol_pin}}));

    // R1: outside reset ports follow requests through latched polarity
    p_track_req_r1: assert property (@(posedge clk) disable iff (rst)
        (rst_pin_n && !clk_strap_pd_en) |->
        (port_pwr == (port_req ^ {NPORT{~strap_status[0]}})));

    // R10: no capture once the qualified reset has ended
    p_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        $past(!clk_strap_pd_en) |-> $stable(strap_status));

    // R7: pull-up covers the whole pull-down window
    p_pu_covers_pd_r7: assert property (@(posedge clk) disable iff (rst)
        clk_strap_pd_en |-> prog_strap_pu_en);

    // R7: pull-up can only drop after pull-down has dropped
    p_pu_after_pd_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(prog_strap_pu_en) |-> $past(!clk_strap_pd_en));

    // R6: pull-down release follows a high pin through the synchroniser
    p_sync_release_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_strap_pd_en) |-> $past(rst_pin_n, 2));

endmodule

bind boot_strap_ctl bstrap_checker #(.NPORT(NPORT)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .rst_pin_n        (rst_pin_n),
    .pol_pin          (pol_pin),
    .port_req         (port_req),
    .clk_strap_pd_en  (clk_strap_pd_en),
    .prog_strap_pu_en (prog_strap_pu_en),
    .strap_status     (strap_status),
    .port_pwr         (port_pwr)
);

// File: tb/boot_strap_ctl_bench.sv
module boot_strap_ctl_bench;
    localparam int NPORT   = 3;
    localparam int MIN_LOW = 24;
    localparam int REL_DLY = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             rst_pin_n;
    logic             pol_pin;
    logic             clk_mode_pin;
    logic [1:0]       clk_sel_pin;
    logic             prog_mem_pin;
    logic [NPORT-1:0] port_req;
    logic             pd_en;
    logic             pu_en;
    logic [4:0]       status;
    logic [NPORT-1:0] port_pwr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    boot_strap_ctl #(
        .NPORT   (NPORT),
        .MIN_LOW (MIN_LOW),
        .REL_DLY (REL_DLY)
    ) u_boot_strap_ctl (
        .clk              (clk),
        .rst              (rst),
        .rst_pin_n        (rst_pin_n),
        .pol_pin          (pol_pin),
        .clk_mode_pin     (clk_mode_pin),
        .clk_sel_pin      (clk_sel_pin),
        .prog_mem_pin     (prog_mem_pin),
        .port_req         (port_req),
        .clk_strap_pd_en  (pd_en),
        .prog_strap_pu_en (pu_en),
        .strap_status     (status),
        .port_pwr         (port_pwr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_straps(input logic [4:0] v);
        pol_pin      = v[0];
        clk_mode_pin = v[1];
        clk_sel_pin  = v[3:2];
        prog_mem_pin = v[4];
    endtask

    function automatic int exp_port(input int req, input int pol);
        return pol ? req : (~req & ((1 << NPORT) - 1));
    endfunction

    // Pin low for n rising edges; starts and ends at a falling edge.
    task automatic low_pulse(input int n);
        rst_pin_n = 1'b0;
        repeat (n) @(negedge clk);
        rst_pin_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        rst_pin_n = 1'b1;
        port_req = '0;
        set_straps(5'h00);
        repeat (3) @(negedge clk);

        // R11: initialisation state
        chk("R11 pd", int'(pd_en), 1);
        chk("R11 pu", int'(pu_en), 1);
        chk("R11 status", int'(status), 0);
        for (int p = 0; p < 2; p++) begin
            pol_pin = p[0]; port_req = '1; #1;
            chk("R2 rst idle", int'(port_pwr), p ? 0 : 7);
        end
        rst = 1'b0;
        repeat (20) @(negedge clk);

        // R4 R5 R1 R3 R10 R6 R7: every strap combination
        for (int v = 0; v < 32; v++) begin
            int pdc, puc;
            set_straps(v[4:0]);
            low_pulse(MIN_LOW + 10);
            pdc = 0; puc = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                pdc += int'(pd_en);
                puc += int'(pu_en);
            end
            chk("R6 pd window", pdc, 2);
            chk("R7 pu window", puc, REL_DLY + 2);
            chk("R4 status", int'(status), v);
            chk("R5 rom select", int'(status[4]), (v >> 4) & 1);
            set_straps(~v[4:0]);
            for (int r = 0; r < 8; r++) begin
                port_req = r[NPORT-1:0]; #1;
                chk("R1 R3 port", int'(port_pwr), exp_port(r, v & 1));
            end
            @(negedge clk);
            chk("R10 hold", int'(status), v);
        end

        // R2: live polarity gating while the pin is low
        rst_pin_n = 1'b0;
        for (int p = 0; p < 2; p++) begin
            for (int r = 0; r < 8; r++) begin
                pol_pin = p[0]; port_req = r[NPORT-1:0]; #1;
                chk("R2 idle", int'(port_pwr), p ? 0 : 7);
            end
        end
        repeat (MIN_LOW + 4) @(negedge clk);
        set_straps(5'h15);
        rst_pin_n = 1'b1;
        repeat (REL_DLY + 6) @(negedge clk);
        chk("R4 relatch", int'(status), 5'h15);

        // R8: glitch one edge short of qualifying
        begin
            int pdc;
            set_straps(5'h0A);
            pdc = 0;
            rst_pin_n = 1'b0;
            for (int k = 0; k < MIN_LOW - 1; k++) begin
                @(negedge clk);
                pdc += int'(pd_en);
            end
            rst_pin_n = 1'b1;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                pdc += int'(pd_en | pu_en);
            end
            chk("R8 pulls off", pdc, 0);
            chk("R8 status kept", int'(status), 5'h15);
        end

        // R9: exactly qualifying pulse
        begin
            int pdc;
            set_straps(5'h0A);
            low_pulse(MIN_LOW);
            pdc = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                pdc += int'(pd_en);
            end
            repeat (REL_DLY + 4) @(negedge clk);
            chk("R9 pd seen", int'(pdc > 0), 1);
            chk("R9 status", int'(status), 5'h0A);
            port_req = 3'b101; #1;
            chk("R1 low polarity", int'(port_pwr), 3'b010);
        end

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule